// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block is an 8-bit serial shift port for a small microcontroller. A byte is placed into the shift register by a parallel load. Setting the busy flag starts a transfer, which moves the byte out most significant bit first while a new byte enters at the least significant end. When the transfer ends, the received byte can be read back in parallel. The port runs either as master, making the shift clock by dividing the system clock, or as slave, taking the shift clock from an external pin through a synchronizer.

A control word selects the operating mode:
- whether the port drives the shift clock (master) or receives it (slave);
- whether the data-out pin is driven or left floating;
- the master clock divider;
- the clock phase, which decides which edge samples input data and which edge changes output data;
- whether a completed byte raises an interrupt request.

Software can stop a transfer early by clearing the busy flag. Pin tristate is shown as output-enable signals.

Top module: `ssp_port`

## Requirements
- R1: After reset, busy, irq, sck_out, sck_oe, sdo_oe and rd_data are all 0, and the phase setting is normal.
- R2: Writing busy to 1 starts a transfer. In master mode exactly eight shift-clock pulses follow, and busy returns to 0 by itself on the eighth falling edge.
- R3: In master mode each shift-clock high or low phase lasts 2^div system clocks, where div is ctl_wdata[4:3]. The full period is therefore 2, 4, 8 or 16 clocks.
- R4: With normal phase (ctl_wdata[2]=0), sdi is sampled on the rising shift-clock edge and sdo changes on the falling edge. Data moves MSB first and enters at the LSB, so after a full byte rd_data holds the received byte.
- R5: With alternate phase (ctl_wdata[2]=1), sdo changes on the rising edge and sdi is sampled on the falling edge. The byte ordering is the same as in R4.
- R6: Writing busy to 0 during a transfer stops it at once. No further shift-clock pulses appear and no irq is raised.
- R7: When irq is enabled (ctl_wdata[5]=1), irq is a one-cycle pulse in the cycle after busy clears at the end of a full byte. With irq disabled, irq stays 0.
- R8: sck_oe follows ctl_wdata[0] (1 = master) and sdo_oe follows ctl_wdata[1] (1 = driven). In slave mode sck_out stays 0.
- R9: In slave mode the shift clock comes from sck_in through a two-flop synchronizer. Eight falling edges complete a byte. Edges on sck_in while busy is 0 leave the shift register unchanged.
- R10: sck_out is 0 whenever busy is 0.
- R11: A parallel load is visible on rd_data in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 6 | Control word: [5] irq enable, [4:3] divider, [2] phase, [1] data-out drive, [0] master |
| busy_we | input | 1 | Write strobe for the busy flag |
| busy_wval | input | 1 | Value written to the busy flag |
| load_we | input | 1 | Parallel load strobe |
| load_data | input | 8 | Parallel load value |
| rd_data | output | 8 | Shift register contents |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Byte-complete interrupt pulse |
| sck_in | input | 1 | External shift clock (slave) |
| sck_out | output | 1 | Generated shift clock (master) |
| sck_oe | output | 1 | Output enable for the shift-clock pin |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the data-out pin |

## Verification
A wrong bit count inside the port shows on the pins within one transfer, as a ninth or a missing shift-clock pulse, or as busy clearing at the wrong time. A divider or phase fault shows within two shift-clock edges, as a wrong pulse width or as a bit captured at the wrong edge. That bit then appears in the final rd_data or in the serial stream the bench collects from sdo. An abort or synchronizer fault shows as stray pulses, a stray irq, or a changed rd_data when the external clock toggles while the port is idle.

// File: rtl/ssp_pkg.sv
// Shared definitions for the serial shift port.
// Assumes a 6-bit control word whose bit order is set by the struct below.
package ssp_pkg;
    localparam int SSP_DIV_W = 2;
    localparam int SSP_CFG_W = 6;

    typedef struct packed {
        logic                 irq_en;      // [5]
        logic [SSP_DIV_W-1:0] div_sel;     // [4:3]
        logic                 phase_alt;   // [2]
        logic                 dout_drive;  // [1]
        logic                 clk_master;  // [0]
    } ssp_cfg_t;
endpackage

// File: rtl/ssp_clkgen.sv
// Master shift-clock generator.
// While run is high it toggles sck every 2^div_sel system clocks and flags the
// edge it is about to make. When run is low, sck is held low and the count is cleared.
// Assumes div_sel does not change while run is high.
module ssp_clkgen #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             sck,
    output logic             rise,
    output logic             fall
);
    localparam int CNT_W = 2 ** DIV_W;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;
    logic             wrap;

    // Last count value of one half period.
    assign half_m1 = (CNT_W'(1) << div_sel) - CNT_W'(1);
    assign wrap    = run && (cnt == half_m1);
    assign rise    = wrap && !sck;
    assign fall    = wrap && sck;

    // Half-period counter and clock level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            sck <= ~sck;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/ssp_edge_sync.sv
// Synchronizer and edge detector for an external clock pin.
// Produces one-cycle rise and fall strobes, STAGES+1 system clocks after the pin moves.
// Assumes the pin stays at each level for more than two system clocks.
module ssp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Synchronizer chain followed by a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] && !prev_q;
    assign fall = !sync_q[STAGES-1] && prev_q;
endmodule

// File: rtl/ssp_shifter.sv
// Shift register with phase-selectable sampling and a bit counter.
// Normal phase: sdi is held at rise and shifted in at fall, and sdo is the MSB.
// Alternate phase: sdo is updated at rise and sdi is shifted in at fall.
// Assumes rise and fall already carry the transfer gating.
// A load takes priority over a shift.
module ssp_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_we,
    input  logic [DATA_W-1:0] load_data,
    input  logic              start,
    input  logic              phase_alt,
    input  logic              rise,
    input  logic              fall,
    input  logic              sdi,
    output logic [DATA_W-1:0] data,
    output logic              sdo,
    output logic              done
);
    localparam int CNT_W = $clog2(DATA_W);

    logic [CNT_W-1:0] bit_cnt;
    logic             held_q;
    logic             out_q;

    assign done = fall && (bit_cnt == CNT_W'(DATA_W - 1));
    assign sdo  = phase_alt ? out_q : data[DATA_W-1];

    // Shift register: parallel load, or one bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data <= '0;
        else if (load_we)
            data <= load_data;
        else if (fall)
            data <= {data[DATA_W-2:0], phase_alt ? sdi : held_q};
    end

    // Rising-edge registers: held input (normal) and output bit (alternate).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            out_q  <= 1'b0;
        end else if (rise) begin
            held_q <= sdi;
            out_q  <= data[DATA_W-1];
        end
    end

    // Bit counter: cleared on start, advanced on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || start)
            bit_cnt <= '0;
        else if (fall)
            bit_cnt <= bit_cnt + CNT_W'(1);
    end
endmodule

// File: rtl/ssp_port.sv
// Top of the serial shift port.
// Holds the control word and the busy flag, picks the master or slave clock
// source, and raises the byte-complete interrupt.
// Assumes the host changes the control word and loads data only while the port is idle.
module ssp_port #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [5:0]        ctl_wdata,
    input  logic              busy_we,
    input  logic              busy_wval,
    input  logic              load_we,
    input  logic [DATA_W-1:0] load_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              irq,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe
);
    import ssp_pkg::*;

    ssp_cfg_t cfg_q;
    logic     run, start, done;
    logic     m_sck, m_rise, m_fall;
    logic     s_rise, s_fall;
    logic     sh_rise, sh_fall;

    // A software clear stops all activity in the same cycle it is written.
    assign run   = busy && !(busy_we && !busy_wval);
    assign start = busy_we && busy_wval;

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (ctl_we)
            cfg_q <= ssp_cfg_t'(ctl_wdata);
    end

    // Busy flag: host write wins, otherwise cleared when a byte completes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (busy_we)
            busy <= busy_wval;
        else if (done)
            busy <= 1'b0;
    end

    // Interrupt pulse one cycle after completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= done && cfg_q.irq_en;
    end

    ssp_clkgen #(.DIV_W(SSP_DIV_W)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run && cfg_q.clk_master),
        .div_sel (cfg_q.div_sel),
        .sck     (m_sck),
        .rise    (m_rise),
        .fall    (m_fall)
    );

    ssp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (sck_in),
        .rise  (s_rise),
        .fall  (s_fall)
    );

    assign sh_rise = cfg_q.clk_master ? m_rise : (run && s_rise);
    assign sh_fall = cfg_q.clk_master ? m_fall : (run && s_fall);

    ssp_shifter #(.DATA_W(DATA_W)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_we   (load_we),
        .load_data (load_data),
        .start     (start),
        .phase_alt (cfg_q.phase_alt),
        .rise      (sh_rise),
        .fall      (sh_fall),
        .sdi       (sdi),
        .data      (rd_data),
        .sdo       (sdo),
        .done      (done)
    );

    assign sck_out = cfg_q.clk_master && m_sck;
    assign sck_oe  = cfg_q.clk_master;
    assign sdo_oe  = cfg_q.dout_drive;
endmodule

// File: rtl/ssp_port_chk.sv
// Protocol checks for ssp_port, attached with the bind below.
// Assumes it is clocked and reset like the port it watches.
module ssp_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              irq,
    input logic              sck_out,
    input logic              sck_oe,
    input logic              busy_we,
    input logic              busy_wval,
    input logic              load_we,
    input logic [DATA_W-1:0] load_data,
    input logic [DATA_W-1:0] rd_data
);
    a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck_out);

    a_r7_irq_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!busy && $past(busy)));

    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r8_slave_no_clk: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_oe |-> !sck_out);

    a_r11_load_visible: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> (rd_data == $past(load_data)));

    a_r2_start_by_host: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy)) |-> $past(busy_we && busy_wval));
endmodule

bind ssp_port ssp_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .irq       (irq),
    .sck_out   (sck_out),
    .sck_oe    (sck_oe),
    .busy_we   (busy_we),
    .busy_wval (busy_wval),
    .load_we   (load_we),
    .load_data (load_data),
    .rd_data   (rd_data)
);

// File: tb/ssp_port_bench.sv
// Bench for ssp_port: directed corner cases plus seeded random transfers.
module ssp_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [5:0] ctl_wdata = '0;
    logic       busy_we = 1'b0, busy_wval = 1'b0;
    logic       load_we = 1'b0;
    logic [7:0] load_data = '0;
    logic [7:0] rd_data;
    logic       busy, irq, sck_out, sck_oe, sdo, sdo_oe;
    logic       sck_in = 1'b0;
    logic       sdi;
    logic       sdi_m = 1'b0, sdi_s = 1'b0, use_m = 1'b0;

    int n_chk = 0, n_fail = 0;
    bit mon = 0, first = 0, alt_b = 0;
    logic prev_sck = 1'b0;
    int rises = 0, falls = 0, gap = 0, gap_bad = 0, half_exp = 1, irq_cnt = 0;
    logic [7:0] cap_b = '0, sdi_b = '0;

    always #5 clk = ~clk;
    assign sdi = use_m ? sdi_m : sdi_s;

    ssp_port u_ssp_port (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .busy_we(busy_we), .busy_wval(busy_wval), .load_we(load_we),
        .load_data(load_data), .rd_data(rd_data), .busy(busy), .irq(irq),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Master-mode pin monitor: edge counts, half-period widths, serial capture.
    always @(negedge clk) begin
        if (irq) irq_cnt++;
        if (mon) begin
            gap++;
            if (sck_out !== prev_sck) begin
                if (!first && gap != half_exp) gap_bad++;
                first = 0;
                gap = 0;
                if (sck_out) begin
                    rises++;
                    if (!alt_b) cap_b = {cap_b[6:0], sdo};
                    else begin sdi_m = sdi_b[7]; sdi_b = sdi_b << 1; end
                end else begin
                    falls++;
                    if (alt_b) cap_b = {cap_b[6:0], sdo};
                    else begin sdi_b = sdi_b << 1; sdi_m = sdi_b[7]; end
                end
            end
        end
        prev_sck = sck_out;
    end

    task automatic setup(input logic [5:0] cw, input logic [7:0] tx);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = cw;
        @(negedge clk); ctl_we = 1'b0; load_we = 1'b1; load_data = tx;
        @(negedge clk); load_we = 1'b0;
        chk(rd_data == tx, "R11 load", rd_data, tx);
        chk(sck_oe == cw[0] && sdo_oe == cw[1], "R8 oe", {sck_oe, sdo_oe}, {cw[0], cw[1]});
    endtask

    task automatic start_busy();
        busy_we = 1'b1; busy_wval = 1'b1;
        @(negedge clk); busy_we = 1'b0;
    endtask

    task automatic do_master(input bit [1:0] dv, input bit alt, input bit ie,
                             input bit drv, input bit [7:0] tx, input bit [7:0] rx);
        setup({ie, dv, alt, drv, 1'b1}, tx);
        use_m = 1'b1; sdi_b = rx; sdi_m = rx[7]; alt_b = alt;
        rises = 0; falls = 0; cap_b = '0; gap = 0; gap_bad = 0; first = 1;
        half_exp = 1 << dv; irq_cnt = 0; mon = 1;
        start_busy();
        for (int i = 0; i < 400 && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        mon = 0;
        chk(rises == 8 && falls == 8, "R2 pulse count", rises, 8);
        chk(busy == 1'b0, "R2 busy self-clear", busy, 0);
        chk(gap_bad == 0, "R3 half period", gap_bad, 0);
        chk(rd_data == rx, alt ? "R5 rx byte" : "R4 rx byte", rd_data, rx);
        chk(cap_b == tx, alt ? "R5 tx stream" : "R4 tx stream", cap_b, tx);
        chk(irq_cnt == int'(ie), "R7 irq count", irq_cnt, ie);
        chk(sck_out == 1'b0, "R10 idle low", sck_out, 0);
    endtask

    task automatic do_slave(input bit alt, input bit ie, input bit drv,
                            input bit [7:0] tx, input bit [7:0] rx);
        logic [7:0] cap = '0;
        setup({ie, 2'b00, alt, drv, 1'b0}, tx);
        use_m = 1'b0; irq_cnt = 0; sdi_s = rx[7];
        start_busy();
        repeat (2) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            if (!alt) begin
                repeat (5) @(negedge clk);
                cap = {cap[6:0], sdo};
                sck_in = 1'b1;
                repeat (5) @(negedge clk);
                sck_in = 1'b0;
                if (k < 7) sdi_s = rx[6-k];
            end else begin
                sck_in = 1'b1; sdi_s = rx[7-k];
                repeat (5) @(negedge clk);
                cap = {cap[6:0], sdo};
                sck_in = 1'b0;
                repeat (5) @(negedge clk);
            end
        end
        repeat (6) @(negedge clk);
        chk(busy == 1'b0, "R9 slave done", busy, 0);
        chk(rd_data == rx, alt ? "R5 slave rx" : "R4 slave rx", rd_data, rx);
        chk(cap == tx, alt ? "R5 slave tx" : "R4 slave tx", cap, tx);
        chk(irq_cnt == int'(ie), "R7 slave irq", irq_cnt, ie);
        chk(sck_out == 1'b0, "R8 slave sck quiet", sck_out, 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int r;
        void'($urandom(32'h5EED));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0 && irq == 0 && sck_out == 0, "R1 reset flags", {busy, irq, sck_out}, 0);
        chk(sck_oe == 0 && sdo_oe == 0 && rd_data == 0, "R1 reset config", {sck_oe, sdo_oe, rd_data}, 0);

        // Directed: fastest and slowest divider, both phases
        do_master(2'd0, 1'b0, 1'b1, 1'b1, 8'hA5, 8'h3C);
        do_master(2'd3, 1'b1, 1'b0, 1'b0, 8'h81, 8'h7E);
        do_slave(1'b0, 1'b1, 1'b1, 8'hC3, 8'h5A);
        do_slave(1'b1, 1'b1, 1'b0, 8'h01, 8'hFE);

        // R6 abort mid-transfer
        setup({1'b1, 2'd3, 1'b0, 1'b1, 1'b1}, 8'hF0);
        use_m = 1'b1; rises = 0; falls = 0; irq_cnt = 0; first = 1; half_exp = 8; mon = 1;
        start_busy();
        repeat (40) @(negedge clk);
        busy_we = 1'b1; busy_wval = 1'b0;
        @(negedge clk); busy_we = 1'b0;
        r = rises;
        repeat (100) @(negedge clk);
        mon = 0;
        chk(busy == 1'b0, "R6 busy cleared", busy, 0);
        chk(rises == r && rises < 8, "R6 no more pulses", rises, r);
        chk(irq_cnt == 0, "R6 no irq", irq_cnt, 0);
        chk(sck_out == 1'b0, "R10 low after abort", sck_out, 0);

        // R9 idle slave ignores external edges
        setup({1'b1, 2'd0, 1'b0, 1'b1, 1'b0}, 8'hA5);
        irq_cnt = 0;
        for (int k = 0; k < 8; k++) begin
            sck_in = 1'b1; sdi_s = ~sdi_s; repeat (4) @(negedge clk);
            sck_in = 1'b0; repeat (4) @(negedge clk);
        end
        chk(rd_data == 8'hA5, "R9 idle edges ignored", rd_data, 8'hA5);
        chk(busy == 0 && irq_cnt == 0, "R9 idle no activity", {busy, irq_cnt}, 0);

        // Random transfers
        for (int t = 0; t < 16; t++) begin
            bit [7:0] tx = 8'($urandom);
            bit [7:0] rx = 8'($urandom);
            bit [1:0] dv = 2'($urandom);
            bit alt = 1'($urandom), ie = 1'($urandom), drv = 1'($urandom);
            if ($urandom % 2 == 0) do_master(dv, alt, ie, drv, tx, rx);
            else                   do_slave(alt, ie, drv, tx, rx);
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule